// File: doc/BRIEF.md
# Configuration Header Register File

This block holds the device side of one function's 256-byte configuration space, seen as 64 DWORD slots. The lowest sixteen slots form the standard header. The header holds the fixed identity values (vendor, device, revision, subsystem pair and the three-byte class code), the header-type byte with its multi-function flag, a command register, a status register, and six base address registers. The upper 48 slots belong to the device's own extension logic. Requests to those slots are forwarded on a side port, and the extension logic's read data is returned as the response.

A configuration request is presented for one cycle with a DWORD index, four byte enables and write data. A read returns its data one cycle later with a response strobe. The block also drives the decoded enables held in the command register (I/O decode, memory decode, bus mastering) and the programmed base address of every range. Bus events raised by the rest of the device are latched into sticky status bits, which software clears by writing ones to them.

Top module: `cfg_hdr_regfile`

## Requirements
- R1: DWORD 0 reads {DEVICE_ID, VENDOR_ID}, DWORD 2 reads {CLASS_CODE[23:0], REV_ID} and DWORD 11 reads {SUB_ID, SUB_VENDOR}. Writes to these slots change nothing.
- R2: DWORD 3 bits 23:16 (byte offset 0x0E) hold the header type: 0x80 when MULTI_FN is 1, otherwise 0x00. All other bytes of that slot read 0. Writes change nothing.
- R3: The command register is in DWORD 1 bits 15:0. Bit 0 (I/O decode), bit 1 (memory decode) and bit 2 (bus master) are writable through byte enable 0 and drive io_space_en, mem_space_en and bus_master_en. The other command bits read 0.
- R4: The status register is in DWORD 1 bits 31:16. Status bits 10:4 return the constant STATUS_CAPS. Status bits 15:11 are sticky event bits: evt_in[k] sets bit 11+k. Writing 1 to a set bit, with byte enable 3, clears it. Writing 0 leaves it unchanged. A set and a clear in the same cycle leave the bit set.
- R5: BAR n sits in DWORD 4+n. With size log2 L, bits below L read 0, so a write of all ones reads back ~(2^L-1). Bit 0 reads 1 for an I/O range and 0 for a memory range.
- R6: A BAR whose size log2 is 0 is absent. It reads 0 and ignores writes.
- R7: A write changes only the bytes whose byte enable is set.
- R8: DWORDs 10 and 12 to 15 read 0.
- R9: Requests to DWORDs 16 to 63 appear on the ext_* port in the same cycle, and a read there returns ext_rdata. Requests to DWORDs 0 to 15 leave ext_valid low.
- R10: A read raises rsp_valid with its data exactly one cycle later. A write produces no response.
- R11: After reset the command register, the status event bits, all BARs and rsp_valid are 0.
- R12: bar_base[32n+31:32n] shows the stored base of BAR n, without the type bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 6 | DWORD index in configuration space |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| evt_in | input | 5 | Event pulses that set status bits 15:11 |
| ext_rdata | input | 32 | Read data from extension logic |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| ext_valid | output | 1 | Request to extension slots 16..63 |
| ext_write | output | 1 | Extension request is a write |
| ext_index | output | 6 | Extension DWORD index |
| ext_be | output | 4 | Extension byte enables |
| ext_wdata | output | 32 | Extension write data |
| io_space_en | output | 1 | Command bit 0 |
| mem_space_en | output | 1 | Command bit 1 |
| bus_master_en | output | 1 | Command bit 2 |
| bar_base | output | 192 | Six programmed base addresses, BAR 0 in the low word |

## Verification
Some rules are checked by assertions in every cycle: event bits stay set until cleared by a write, a raised event is latched, the command register and every BAR hold their value when not written, an all-ones BAR write latches exactly the size mask, and each response follows a read. The fixed header contents, the merging of byte enables, the absent BAR, the zero reserved slots, the extension forwarding and the set-over-clear priority can only be shown by the bench's read-back scenarios, because they depend on the parameter values and on the exact read data.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  localparam int BAR_COUNT = 6;
  localparam int EVT_W     = 5;
  localparam int EVT_LSB   = 11;
  localparam int CMD_W     = 3;

  localparam logic [5:0] IDX_ID      = 6'd0;
  localparam logic [5:0] IDX_CMDSTAT = 6'd1;
  localparam logic [5:0] IDX_CLASS   = 6'd2;
  localparam logic [5:0] IDX_MISC    = 6'd3;
  localparam logic [5:0] IDX_BAR0    = 6'd4;
  localparam logic [5:0] IDX_SUBSYS  = 6'd11;

  // status bits that carry constant capability information
  localparam logic [15:0] STAT_CAP_MASK = 16'h07F0;

  function automatic logic [31:0] be_to_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[b*8 +: 8] = {8{be[b]}};
    return m;
  endfunction
endpackage

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot #(
  parameter int SIZE_LOG2 = 12,
  parameter bit IS_IO     = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic [31:0] base
);
  import cfg_hdr_pkg::*;

  localparam bit          PRESENT = (SIZE_LOG2 != 0);
  localparam logic [31:0] AMASK   = PRESENT ? (32'hFFFF_FFFF << SIZE_LOG2) : 32'h0;
  localparam logic [31:0] TYPEBIT = (PRESENT && IS_IO) ? 32'h1 : 32'h0;

  logic [31:0] bmask;
  assign bmask = be_to_mask(be);

  always_ff @(posedge clk) begin
    if (rst) base <= '0;
    else if (wr_en) base <= ((base & ~bmask) | (wdata & bmask)) & AMASK;
  end

  assign rdata = base | TYPEBIT;

  assert_bar_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(base));
  assert_bar_size_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && be == 4'hF && wdata == 32'hFFFF_FFFF) |=> (base == AMASK));
endmodule

// File: rtl/cfg_cmd_stat.sv
module cfg_cmd_stat #(
  parameter logic [15:0] STATUS_CAPS = 16'h0010
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [3:0]                    be,
  input  logic [cfg_hdr_pkg::CMD_W-1:0] cmd_wbits,
  input  logic [cfg_hdr_pkg::EVT_W-1:0] evt_clr_bits,
  input  logic [cfg_hdr_pkg::EVT_W-1:0] evt_in,
  output logic [cfg_hdr_pkg::CMD_W-1:0] cmd,
  output logic [15:0]                   stat
);
  import cfg_hdr_pkg::*;

  logic [EVT_W-1:0] evt;
  logic [EVT_W-1:0] clr;

  assign clr = (wr_en && be[3]) ? evt_clr_bits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd <= '0;
      evt <= '0;
    end else begin
      if (wr_en && be[0]) cmd <= cmd_wbits;
      evt <= (evt & ~clr) | evt_in;
    end
  end

  always_comb begin
    stat = STATUS_CAPS & STAT_CAP_MASK;
    stat[EVT_LSB +: EVT_W] = evt;
  end

  assert_evt_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && be[3]) |=> ((evt & $past(evt)) == $past(evt)));
  assert_evt_latch_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((evt & $past(evt_in)) == $past(evt_in)));
  assert_cmd_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && be[0]) |=> $stable(cmd));
endmodule

// File: rtl/cfg_hdr_regfile.sv
module cfg_hdr_regfile #(
  parameter logic [15:0] VENDOR_ID   = 16'hA5C3,
  parameter logic [15:0] DEVICE_ID   = 16'h7E21,
  parameter logic [7:0]  REV_ID      = 8'h03,
  parameter logic [23:0] CLASS_CODE  = 24'h028000,
  parameter logic [15:0] SUB_VENDOR  = 16'h5B17,
  parameter logic [15:0] SUB_ID      = 16'h0C4E,
  parameter bit          MULTI_FN    = 1'b1,
  parameter logic [15:0] STATUS_CAPS = 16'h0010,
  parameter logic [35:0] BAR_LOG2    = {6'd0, 6'd0, 6'd0, 6'd20, 6'd8, 6'd12},
  parameter logic [5:0]  BAR_IS_IO   = 6'b000010
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_valid,
  input  logic         req_write,
  input  logic [5:0]   req_index,
  input  logic [3:0]   req_be,
  input  logic [31:0]  req_wdata,
  input  logic [4:0]   evt_in,
  input  logic [31:0]  ext_rdata,
  output logic         rsp_valid,
  output logic [31:0]  rsp_rdata,
  output logic         ext_valid,
  output logic         ext_write,
  output logic [5:0]   ext_index,
  output logic [3:0]   ext_be,
  output logic [31:0]  ext_wdata,
  output logic         io_space_en,
  output logic         mem_space_en,
  output logic         bus_master_en,
  output logic [191:0] bar_base
);
  import cfg_hdr_pkg::*;

  localparam logic [7:0] HDR_TYPE = MULTI_FN ? 8'h80 : 8'h00;

  logic            is_ext;
  logic            wr;
  logic [31:0]     bar_rd [BAR_COUNT];
  logic [CMD_W-1:0] cmd;
  logic [15:0]     stat;
  logic [31:0]     rd_mux;

  assign is_ext = (req_index[5:4] != 2'b00);
  assign wr     = req_valid && req_write;

  // extension slots pass straight through
  assign ext_valid = req_valid && is_ext;
  assign ext_write = req_write;
  assign ext_index = req_index;
  assign ext_be    = req_be;
  assign ext_wdata = req_wdata;

  for (genvar i = 0; i < BAR_COUNT; i++) begin : g_bar
    logic [31:0] base_i;
    cfg_bar_slot #(
      .SIZE_LOG2 (int'(BAR_LOG2[i*6 +: 6])),
      .IS_IO     (BAR_IS_IO[i])
    ) u_slot (
      .clk   (clk),
      .rst   (rst),
      .wr_en (wr && (req_index == IDX_BAR0 + 6'(i))),
      .be    (req_be),
      .wdata (req_wdata),
      .rdata (bar_rd[i]),
      .base  (base_i)
    );
    assign bar_base[i*32 +: 32] = base_i;
  end

  cfg_cmd_stat #(.STATUS_CAPS(STATUS_CAPS)) u_cmdstat (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr && (req_index == IDX_CMDSTAT)),
    .be           (req_be),
    .cmd_wbits    (req_wdata[CMD_W-1:0]),
    .evt_clr_bits (req_wdata[16+EVT_LSB +: EVT_W]),
    .evt_in       (evt_in),
    .cmd          (cmd),
    .stat         (stat)
  );

  assign io_space_en   = cmd[0];
  assign mem_space_en  = cmd[1];
  assign bus_master_en = cmd[2];

  always_comb begin
    rd_mux = '0;
    if (is_ext) begin
      rd_mux = ext_rdata;
    end else begin
      case (req_index)
        IDX_ID:      rd_mux = {DEVICE_ID, VENDOR_ID};
        IDX_CMDSTAT: rd_mux = {stat, {(16-CMD_W){1'b0}}, cmd};
        IDX_CLASS:   rd_mux = {CLASS_CODE, REV_ID};
        IDX_MISC:    rd_mux = {8'h00, HDR_TYPE, 16'h0000};
        IDX_SUBSYS:  rd_mux = {SUB_ID, SUB_VENDOR};
        default:     rd_mux = '0;
      endcase
      for (int i = 0; i < BAR_COUNT; i++)
        if (req_index == IDX_BAR0 + 6'(i)) rd_mux = bar_rd[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rsp_rdata <= rd_mux;
    end
  end

  assert_rsp_follows_read_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && !req_write));
  assert_read_gets_rsp_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rsp_valid);
endmodule

// File: tb/cfg_hdr_regfile_tb.sv
`timescale 1ns/1ps
module cfg_hdr_regfile_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_write = 1'b0;
  logic [5:0]   req_index = '0;
  logic [3:0]   req_be = '0;
  logic [31:0]  req_wdata = '0;
  logic [4:0]   evt_in = '0;
  logic [31:0]  ext_rdata;
  logic         rsp_valid;
  logic [31:0]  rsp_rdata;
  logic         ext_valid, ext_write;
  logic [5:0]   ext_index;
  logic [3:0]   ext_be;
  logic [31:0]  ext_wdata;
  logic         io_space_en, mem_space_en, bus_master_en;
  logic [191:0] bar_base;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign ext_rdata = 32'hC0DE_0000 | {26'd0, ext_index};

  cfg_hdr_regfile u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_index(req_index), .req_be(req_be), .req_wdata(req_wdata),
    .evt_in(evt_in), .ext_rdata(ext_rdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .ext_valid(ext_valid), .ext_write(ext_write),
    .ext_index(ext_index), .ext_be(ext_be), .ext_wdata(ext_wdata),
    .io_space_en(io_space_en), .mem_space_en(mem_space_en),
    .bus_master_en(bus_master_en), .bar_base(bar_base)
  );

  typedef struct packed {
    logic        wr;
    logic [5:0]  idx;
    logic [3:0]  be;
    logic [31:0] wdata;
    logic [31:0] exp;
  } vec_t;

  localparam int NVEC = 28;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 6'd0,  4'hF, 32'h0,        32'h7E21_A5C3}, // R1 identity
    '{1'b0, 6'd2,  4'hF, 32'h0,        32'h0280_0003}, // R1 class/rev
    '{1'b0, 6'd11, 4'hF, 32'h0,        32'h0C4E_5B17}, // R1 subsystem
    '{1'b1, 6'd0,  4'hF, 32'hFFFF_FFFF, 32'h0},
    '{1'b0, 6'd0,  4'hF, 32'h0,        32'h7E21_A5C3}, // R1 write ignored
    '{1'b0, 6'd3,  4'hF, 32'h0,        32'h0080_0000}, // R2 header type
    '{1'b1, 6'd3,  4'hF, 32'hFFFF_FFFF, 32'h0},
    '{1'b0, 6'd3,  4'hF, 32'h0,        32'h0080_0000}, // R2 write ignored
    '{1'b0, 6'd1,  4'hF, 32'h0,        32'h0010_0000}, // R4 caps, R11 cmd zero
    '{1'b1, 6'd4,  4'hF, 32'hFFFF_FFFF, 32'h0},
    '{1'b0, 6'd4,  4'hF, 32'h0,        32'hFFFF_F000}, // R5 memory 4 KiB
    '{1'b1, 6'd5,  4'hF, 32'hFFFF_FFFF, 32'h0},
    '{1'b0, 6'd5,  4'hF, 32'h0,        32'hFFFF_FF01}, // R5 I/O 256 B
    '{1'b1, 6'd6,  4'hF, 32'hFFFF_FFFF, 32'h0},
    '{1'b0, 6'd6,  4'hF, 32'h0,        32'hFFF0_0000}, // R5 memory 1 MiB
    '{1'b1, 6'd7,  4'hF, 32'hFFFF_FFFF, 32'h0},
    '{1'b0, 6'd7,  4'hF, 32'h0,        32'h0},         // R6 absent BAR
    '{1'b1, 6'd6,  4'h8, 32'h1234_5678, 32'h0},
    '{1'b0, 6'd6,  4'hF, 32'h0,        32'h12F0_0000}, // R7 top byte only
    '{1'b1, 6'd4,  4'h3, 32'h0000_ABCD, 32'h0},
    '{1'b0, 6'd4,  4'hF, 32'h0,        32'hFFFF_A000}, // R7 low bytes, R5 mask
    '{1'b1, 6'd1,  4'h1, 32'hFFFF_FFFF, 32'h0},
    '{1'b0, 6'd1,  4'hF, 32'h0,        32'h0010_0007}, // R3 command bits
    '{1'b0, 6'd10, 4'hF, 32'h0,        32'h0},         // R8
    '{1'b0, 6'd12, 4'hF, 32'h0,        32'h0},         // R8
    '{1'b0, 6'd15, 4'hF, 32'h0,        32'h0},         // R8
    '{1'b0, 6'd40, 4'hF, 32'h0,        32'hC0DE_0028}, // R9 extension read
    '{1'b0, 6'd16, 4'hF, 32'h0,        32'hC0DE_0010}  // R9 first extension slot
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic [5:0] idx, input logic [3:0] be,
                       input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_index = idx; req_be = be; req_wdata = wd;
  endtask

  task automatic finish_req();
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic do_write(input logic [5:0] idx, input logic [3:0] be, input logic [31:0] wd);
    drive(1'b1, idx, be, wd);
    finish_req();
  endtask

  task automatic read_check(input string tag, input logic [5:0] idx, input logic [31:0] exp);
    drive(1'b0, idx, 4'hF, 32'h0);
    finish_req();
    check({tag, " rsp_valid"}, {31'd0, rsp_valid}, 32'd1);
    check(tag, rsp_rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    check("R11 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R11 cmd outputs", {29'd0, bus_master_en, mem_space_en, io_space_en}, 32'd0);
    check("R11 bar0", bar_base[31:0], 32'd0);

    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v].wr) do_write(VEC[v].idx, VEC[v].be, VEC[v].wdata);
      else read_check($sformatf("vector %0d", v), VEC[v].idx, VEC[v].exp);
    end

    // R12 base outputs
    check("R12 bar0 base", bar_base[31:0], 32'hFFFF_A000);
    check("R12 bar1 base", bar_base[63:32], 32'hFFFF_FF00);
    check("R12 bar2 base", bar_base[95:64], 32'h12F0_0000);
    check("R3 enables", {29'd0, bus_master_en, mem_space_en, io_space_en}, 32'd7);

    // R7 no enables -> no change
    do_write(6'd1, 4'h0, 32'h0);
    read_check("R7 zero enables", 6'd1, 32'h0010_0007);
    // R3 selective command value
    do_write(6'd1, 4'h1, 32'h0000_0005);
    check("R3 enables 101", {29'd0, bus_master_en, mem_space_en, io_space_en}, 32'd5);
    read_check("R3 cmd 5", 6'd1, 32'h0010_0005);

    // R4 event latching
    @(negedge clk); evt_in = 5'b10101;
    @(negedge clk); evt_in = 5'b00000;
    read_check("R4 events set", 6'd1, 32'hA810_0005);
    do_write(6'd1, 4'h7, 32'hFFFF_FFFF);
    read_check("R4 no clear without be3", 6'd1, 32'hA810_0007);
    do_write(6'd1, 4'h8, 32'h0800_0000);
    read_check("R4 write-one clears bit 11", 6'd1, 32'hA010_0007);
    // set and clear of bit 12 in the same cycle
    drive(1'b1, 6'd1, 4'h8, 32'h1000_0000);
    evt_in = 5'b00010;
    finish_req();
    evt_in = 5'b00000;
    read_check("R4 set wins", 6'd1, 32'hB010_0007);
    do_write(6'd1, 4'hC, 32'hFFFF_0000);
    read_check("R4 clear all", 6'd1, 32'h0010_0007);

    // R9 extension forwarding of a write
    drive(1'b1, 6'd33, 4'h5, 32'hDEAD_BEEF);
    #1;
    check("R9 ext_valid", {31'd0, ext_valid}, 32'd1);
    check("R9 ext fields", {21'd0, ext_write, ext_index, ext_be}, {21'd0, 1'b1, 6'd33, 4'h5});
    check("R9 ext_wdata", ext_wdata, 32'hDEAD_BEEF);
    finish_req();
    check("R10 no rsp after write", {31'd0, rsp_valid}, 32'd0);
    drive(1'b1, 6'd8, 4'hF, 32'h0);
    #1;
    check("R9 header write not forwarded", {31'd0, ext_valid}, 32'd0);
    finish_req();
    @(negedge clk);
    check("R10 rsp idle", {31'd0, rsp_valid}, 32'd0);

    // R11 reset after programming
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R11 enables cleared", {29'd0, bus_master_en, mem_space_en, io_space_en}, 32'd0);
    check("R11 bar2 cleared", bar_base[95:64], 32'd0);
    read_check("R11 bar0 read", 6'd4, 32'h0);
    read_check("R11 cmdstat read", 6'd1, 32'h0010_0000);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule